// File: doc/BRIEF.md
# CPU Clock Operating-Point Sequencer

This block is a hardware state machine that moves the CPU clock domain from one operating point to another. A requester presents a level index on a valid/ready handshake. The block checks the index and rejects any value outside the supported set. For a valid index it performs a fixed, status-gated sequence:

1. Load the two CPU divider words and wait for their busy flags to clear.
2. Move the CPU clock mux onto the secondary PLL.
3. Program a lock time and the primary PLL control word.
4. Wait for the PLL to report lock.
5. Move the mux back to the primary PLL.

Every step waits for the matching hardware status before the next one starts.

The register-style outputs (divider words, mux select, lock time, PLL control word) are held between updates. The divider words and the PLL word each come with a one-cycle write strobe. The status inputs are the two divider status words, the mux status field and the PLL lock flag. After reset the block runs one change to the 1600 MHz level by itself. The stored current level can be read at any time and changes only when a sequence completes.

Top module: `cpu_clk_seq`

## Requirements
- R1: Level indices 0 to 8 are accepted and stand for 200, 400, 600, 800, 1000, 1200, 1400, 1600 and 1700 MHz. An index from 9 to 15 is handshaken and then dropped. `rejected` pulses for one cycle, no output register changes, and `cur_level` keeps its value.
- R2: `div0_word` is loaded from the per-level table {0x1117710, 0x1127710, 0x1137710, 0x2147710, 0x2147710, 0x3157720, 0x4167720, 0x4177730, 0x5377730}, with one `div0_wr` pulse. The sequence holds until bits 0, 4, 8, 12, 16, 20, 24 and 28 of `div0_stat` are all zero. Other bits of that word are ignored.
- R3: `div1_word` is then loaded with the constant 32, with one `div1_wr` pulse. The sequence holds until bits 0 and 4 of `div1_stat` are zero. Other bits are ignored.
- R4: Before the PLL word is written, `lock_time` (20 bits) is loaded with P × 250.
- R5: `pll_con` carries S in [2:0], P in [13:8], M in [25:16] and a 1 in bit 31, with all other bits zero. It is written with one `pll_wr` pulse. The per-level values are P = {3,3,4,3,3,3,3,3,6}, M = {100,100,200,100,125,150,175,200,425} and S = {2,1,1,0,0,0,0,0,0}, so M × 24 MHz / (P × 2^S) equals the level's nominal frequency.
- R6: `mux_sel` = 1 selects the secondary PLL and 0 selects the primary PLL. After each switch the block waits until `mux_stat` reads 3'b010 (secondary) or 3'b001 (primary). The PLL word is written only while the mux is parked on the secondary PLL. The return to primary happens only after `pll_locked` is 1.
- R7: The step order is divider 0, divider 1, park, lock time, PLL word, lock, return. `cur_level` updates and `done` pulses for one cycle together, and only once the return to primary is confirmed. Until then `cur_level` holds the previous level.
- R8: After reset the block runs a change to level 7 on its own. `req_ready` stays low until that change completes.
- R9: `req_ready` is high only while the block is idle. A request held during a running sequence is not acknowledged until the sequence ends.
- R10: During reset all output registers and `cur_level` are zero, and `req_ready`, `done` and `rejected` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Level request valid |
| req_level | input | 4 | Requested level index |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rejected | output | 1 | One-cycle pulse: accepted index was out of range |
| done | output | 1 | One-cycle pulse: sequence complete |
| cur_level | output | 4 | Level currently in effect |
| div0_word | output | 32 | First CPU divider word |
| div0_wr | output | 1 | Write strobe for div0_word |
| div1_word | output | 32 | Second CPU divider word |
| div1_wr | output | 1 | Write strobe for div1_word |
| div0_stat | input | 32 | First divider status word |
| div1_stat | input | 32 | Second divider status word |
| mux_sel | output | 1 | CPU clock source: 0 primary PLL, 1 secondary PLL |
| mux_stat | input | 3 | Mux status: 3'b001 primary, 3'b010 secondary |
| lock_time | output | 20 | PLL lock-time count |
| pll_con | output | 32 | Primary PLL control word |
| pll_wr | output | 1 | Write strobe for pll_con |
| pll_locked | input | 1 | Primary PLL lock flag |

## Verification
Each write strobe is registered, so it is high in the cycle after the step is entered. The status inputs are examined only from the third edge after a strobe, which gives a registered status model time to show busy. `rejected` appears in the cycle after the accepting edge. `done` and the new `cur_level` appear in the cycle after the edge that samples `mux_stat` = 3'b001. The monitor samples every falling edge, so each one-cycle strobe is seen exactly once. It matches the strobe against the next queued expectation and checks the status inputs as they stood when that step was issued. The driver only returns after the acknowledging edge, so a request held during a sequence shows up as a measurable wait.

// File: rtl/opp_pkg.sv
package opp_pkg;
  localparam int P_W    = 6;
  localparam int M_W    = 10;
  localparam int S_W    = 3;
  localparam int WORD_W = 32;
  localparam int MUX_W  = 3;

  localparam logic [MUX_W-1:0] MUX_ST_PRI = 3'b001;
  localparam logic [MUX_W-1:0] MUX_ST_SEC = 3'b010;

  typedef struct packed {
    logic [P_W-1:0]    p;
    logic [M_W-1:0]    m;
    logic [S_W-1:0]    s;
    logic [WORD_W-1:0] div0;
  } opp_entry_t;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DIV0,
    ST_DIV0_W,
    ST_DIV1,
    ST_DIV1_W,
    ST_PARK,
    ST_PARK_W,
    ST_LOCKT,
    ST_PMS,
    ST_LOCK_W,
    ST_BACK,
    ST_BACK_W
  } seq_state_t;

  function automatic logic [WORD_W-1:0] pack_pll(input logic [P_W-1:0] p,
                                                 input logic [M_W-1:0] m,
                                                 input logic [S_W-1:0] s);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[2:0]   = s;
    w[13:8]  = p;
    w[25:16] = m;
    w[31]    = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/opp_table.sv
module opp_table
  import opp_pkg::*;
#(
  parameter int LEVEL_W = 4
) (
  input  logic [LEVEL_W-1:0] idx,
  output opp_entry_t         ent
);
  always_comb begin
    case (idx)
      LEVEL_W'(0): ent = '{p: 6'd3, m: 10'd100, s: 3'd2, div0: 32'h0111_7710};
      LEVEL_W'(1): ent = '{p: 6'd3, m: 10'd100, s: 3'd1, div0: 32'h0112_7710};
      LEVEL_W'(2): ent = '{p: 6'd4, m: 10'd200, s: 3'd1, div0: 32'h0113_7710};
      LEVEL_W'(3): ent = '{p: 6'd3, m: 10'd100, s: 3'd0, div0: 32'h0214_7710};
      LEVEL_W'(4): ent = '{p: 6'd3, m: 10'd125, s: 3'd0, div0: 32'h0214_7710};
      LEVEL_W'(5): ent = '{p: 6'd3, m: 10'd150, s: 3'd0, div0: 32'h0315_7720};
      LEVEL_W'(6): ent = '{p: 6'd3, m: 10'd175, s: 3'd0, div0: 32'h0416_7720};
      LEVEL_W'(7): ent = '{p: 6'd3, m: 10'd200, s: 3'd0, div0: 32'h0417_7730};
      LEVEL_W'(8): ent = '{p: 6'd6, m: 10'd425, s: 3'd0, div0: 32'h0537_7730};
      default:     ent = '0;
    endcase
  end
endmodule

// File: rtl/opp_busy_reduce.sv
module opp_busy_reduce #(
  parameter int WORD_W   = 32,
  parameter int NUM_BITS = 8,
  parameter int STRIDE   = 4
) (
  input  logic [WORD_W-1:0] stat,
  output logic              busy
);
  function automatic logic [WORD_W-1:0] mk_mask();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_BITS; i++) m[i*STRIDE] = 1'b1;
    return m;
  endfunction

  localparam logic [WORD_W-1:0] BUSY_MASK = mk_mask();

  generate
    if (NUM_BITS == 0) begin : g_none
      assign busy = 1'b0;
    end else begin : g_mask
      assign busy = |(stat & BUSY_MASK);
    end
  endgenerate
endmodule

// File: rtl/opp_seq_core.sv
module opp_seq_core
  import opp_pkg::*;
#(
  parameter int LEVEL_W    = 4,
  parameter int NUM_LEVELS = 9,
  parameter int BOOT_LEVEL = 7,
  parameter int GUARD_CYC  = 2,
  parameter int LOCK_MULT  = 250,
  parameter int DIV1_CONST = 32,
  parameter int LT_W       = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [LEVEL_W-1:0] req_level,
  output logic               req_ready,
  output logic               rejected,
  output logic               done,
  output logic [LEVEL_W-1:0] cur_level,
  output logic [LEVEL_W-1:0] tgt_level,
  input  opp_entry_t         ent,
  input  logic               div0_busy,
  input  logic               div1_busy,
  input  logic [MUX_W-1:0]   mux_stat,
  input  logic               pll_locked,
  output logic [WORD_W-1:0]  div0_word,
  output logic               div0_wr,
  output logic [WORD_W-1:0]  div1_word,
  output logic               div1_wr,
  output logic               mux_sel,
  output logic [LT_W-1:0]    lock_time,
  output logic [WORD_W-1:0]  pll_con,
  output logic               pll_wr
);
  localparam int GW = $clog2(GUARD_CYC + 1);

  seq_state_t    state;
  logic          boot_pend;
  logic [GW-1:0] guard;
  logic          in_range;

  assign in_range  = {1'b0, req_level} < (LEVEL_W+1)'(NUM_LEVELS);
  assign req_ready = (state == ST_IDLE) && !boot_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      boot_pend <= 1'b1;
      guard     <= '0;
      tgt_level <= '0;
      cur_level <= '0;
      rejected  <= 1'b0;
      done      <= 1'b0;
      div0_word <= '0;
      div0_wr   <= 1'b0;
      div1_word <= '0;
      div1_wr   <= 1'b0;
      mux_sel   <= 1'b0;
      lock_time <= '0;
      pll_con   <= '0;
      pll_wr    <= 1'b0;
    end else begin
      div0_wr  <= 1'b0;
      div1_wr  <= 1'b0;
      pll_wr   <= 1'b0;
      done     <= 1'b0;
      rejected <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (boot_pend) begin
            boot_pend <= 1'b0;
            tgt_level <= LEVEL_W'(BOOT_LEVEL);
            state     <= ST_DIV0;
          end else if (req_valid) begin
            if (in_range) begin
              tgt_level <= req_level;
              state     <= ST_DIV0;
            end else begin
              rejected  <= 1'b1;
            end
          end
        end
        ST_DIV0: begin
          div0_word <= ent.div0;
          div0_wr   <= 1'b1;
          guard     <= GW'(GUARD_CYC);
          state     <= ST_DIV0_W;
        end
        ST_DIV0_W: begin
          if (guard != '0)     guard <= guard - GW'(1);
          else if (!div0_busy) state <= ST_DIV1;
        end
        ST_DIV1: begin
          div1_word <= WORD_W'(DIV1_CONST);
          div1_wr   <= 1'b1;
          guard     <= GW'(GUARD_CYC);
          state     <= ST_DIV1_W;
        end
        ST_DIV1_W: begin
          if (guard != '0)     guard <= guard - GW'(1);
          else if (!div1_busy) state <= ST_PARK;
        end
        ST_PARK: begin
          mux_sel <= 1'b1;
          guard   <= GW'(GUARD_CYC);
          state   <= ST_PARK_W;
        end
        ST_PARK_W: begin
          if (guard != '0)                 guard <= guard - GW'(1);
          else if (mux_stat == MUX_ST_SEC) state <= ST_LOCKT;
        end
        ST_LOCKT: begin
          lock_time <= LT_W'(ent.p) * LT_W'(LOCK_MULT);
          state     <= ST_PMS;
        end
        ST_PMS: begin
          pll_con <= pack_pll(ent.p, ent.m, ent.s);
          pll_wr  <= 1'b1;
          guard   <= GW'(GUARD_CYC);
          state   <= ST_LOCK_W;
        end
        ST_LOCK_W: begin
          if (guard != '0)     guard <= guard - GW'(1);
          else if (pll_locked) state <= ST_BACK;
        end
        ST_BACK: begin
          mux_sel <= 1'b0;
          guard   <= GW'(GUARD_CYC);
          state   <= ST_BACK_W;
        end
        ST_BACK_W: begin
          if (guard != '0) guard <= guard - GW'(1);
          else if (mux_stat == MUX_ST_PRI) begin
            cur_level <= tgt_level;
            done      <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: a rejection follows an accepted handshake
  assert_reject_after_hs_R1: assert property (@(posedge clk) disable iff (rst)
    rejected |-> $past(req_valid && req_ready));

  // R1: stored level never leaves the legal range
  assert_level_legal_R1: assert property (@(posedge clk) disable iff (rst)
    {1'b0, cur_level} < (LEVEL_W+1)'(NUM_LEVELS));

  // R5: only one register write strobe at a time
  assert_one_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({div0_wr, div1_wr, pll_wr}));

  // R6: PLL word is written only while parked on the secondary source
  assert_pms_parked_R6: assert property (@(posedge clk) disable iff (rst)
    pll_wr |-> (mux_sel && mux_stat == MUX_ST_SEC));

  // R4: lock time already holds P x mult when the PLL word goes out
  assert_locktime_first_R4: assert property (@(posedge clk) disable iff (rst)
    pll_wr |-> (lock_time == LT_W'(pll_con[13:8]) * LT_W'(LOCK_MULT)));

  // R7: stored level moves only together with completion
  assert_level_on_done_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(cur_level) |-> done);

  // R9: no acknowledge while a step is outstanding
  assert_no_ack_busy_R9: assert property (@(posedge clk) disable iff (rst)
    (div0_wr || div1_wr || pll_wr) |-> !req_ready);
endmodule

// File: rtl/cpu_clk_seq.sv
module cpu_clk_seq
  import opp_pkg::*;
#(
  parameter int LEVEL_W    = 4,
  parameter int NUM_LEVELS = 9,
  parameter int BOOT_LEVEL = 7,
  parameter int GUARD_CYC  = 2,
  parameter int LOCK_MULT  = 250,
  parameter int DIV1_CONST = 32,
  parameter int LT_W       = 20,
  parameter int DIV0_BUSY_N = 8,
  parameter int DIV1_BUSY_N = 2,
  parameter int BUSY_STRIDE = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [LEVEL_W-1:0] req_level,
  output logic               req_ready,
  output logic               rejected,
  output logic               done,
  output logic [LEVEL_W-1:0] cur_level,
  output logic [31:0]        div0_word,
  output logic               div0_wr,
  output logic [31:0]        div1_word,
  output logic               div1_wr,
  input  logic [31:0]        div0_stat,
  input  logic [31:0]        div1_stat,
  output logic               mux_sel,
  input  logic [2:0]         mux_stat,
  output logic [LT_W-1:0]    lock_time,
  output logic [31:0]        pll_con,
  output logic               pll_wr,
  input  logic               pll_locked
);
  opp_entry_t         ent;
  logic [LEVEL_W-1:0] tgt_level;
  logic               div0_busy;
  logic               div1_busy;

  opp_table #(.LEVEL_W(LEVEL_W)) u_table (
    .idx (tgt_level),
    .ent (ent)
  );

  opp_busy_reduce #(.WORD_W(WORD_W), .NUM_BITS(DIV0_BUSY_N), .STRIDE(BUSY_STRIDE)) u_busy0 (
    .stat (div0_stat),
    .busy (div0_busy)
  );

  opp_busy_reduce #(.WORD_W(WORD_W), .NUM_BITS(DIV1_BUSY_N), .STRIDE(BUSY_STRIDE)) u_busy1 (
    .stat (div1_stat),
    .busy (div1_busy)
  );

  opp_seq_core #(
    .LEVEL_W    (LEVEL_W),
    .NUM_LEVELS (NUM_LEVELS),
    .BOOT_LEVEL (BOOT_LEVEL),
    .GUARD_CYC  (GUARD_CYC),
    .LOCK_MULT  (LOCK_MULT),
    .DIV1_CONST (DIV1_CONST),
    .LT_W       (LT_W)
  ) u_core (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_level  (req_level),
    .req_ready  (req_ready),
    .rejected   (rejected),
    .done       (done),
    .cur_level  (cur_level),
    .tgt_level  (tgt_level),
    .ent        (ent),
    .div0_busy  (div0_busy),
    .div1_busy  (div1_busy),
    .mux_stat   (mux_stat),
    .pll_locked (pll_locked),
    .div0_word  (div0_word),
    .div0_wr    (div0_wr),
    .div1_word  (div1_word),
    .div1_wr    (div1_wr),
    .mux_sel    (mux_sel),
    .lock_time  (lock_time),
    .pll_con    (pll_con),
    .pll_wr     (pll_wr)
  );
endmodule

// File: tb/cpu_clk_seq_tb_top.sv
`timescale 1ns/1ps
module cpu_clk_seq_tb_top;
  localparam int K_DIV0 = 0, K_DIV1 = 1, K_MUX = 2, K_PLL = 3, K_DONE = 4, K_REJ = 5;

  typedef struct {
    int          kind;
    int          lvl;
    logic [31:0] a;
    logic [31:0] b;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [3:0]  req_level = '0;
  logic        req_ready, rejected, done, div0_wr, div1_wr, mux_sel, pll_wr;
  logic [3:0]  cur_level;
  logic [31:0] div0_word, div1_word, pll_con, div0_stat, div1_stat;
  logic [2:0]  mux_stat;
  logic [19:0] lock_time;
  logic        pll_locked;

  int   n_tests = 0;
  int   n_fail  = 0;
  int   last_level = 0;
  logic prev_mux = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  cpu_clk_seq dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_level(req_level),
    .req_ready(req_ready), .rejected(rejected), .done(done), .cur_level(cur_level),
    .div0_word(div0_word), .div0_wr(div0_wr), .div1_word(div1_word), .div1_wr(div1_wr),
    .div0_stat(div0_stat), .div1_stat(div1_stat), .mux_sel(mux_sel), .mux_stat(mux_stat),
    .lock_time(lock_time), .pll_con(pll_con), .pll_wr(pll_wr), .pll_locked(pll_locked)
  );

  // ---------------- status models ----------------
  int          d0cnt, d1cnt, mcnt, pcnt;
  logic [31:0] d0busy, d1busy;
  logic        mux_tgt, lk;
  logic [2:0]  mst;

  assign div0_stat  = 32'h0000_0002 | ((d0cnt != 0) ? d0busy : 32'h0);
  assign div1_stat  = 32'h0000_0100 | ((d1cnt != 0) ? d1busy : 32'h0);
  assign mux_stat   = mst;
  assign pll_locked = lk;

  always @(posedge clk) begin
    if (rst) begin
      d0cnt <= 0; d1cnt <= 0; d0busy <= '0; d1busy <= '0;
      mcnt <= 0; mux_tgt <= 1'b0; mst <= 3'b001;
      lk <= 1'b1; pcnt <= 0;
    end else begin
      if (div0_wr) begin
        d0cnt  <= $urandom_range(6, 1);
        d0busy <= ($urandom() | 32'h1) & 32'h1111_1111;
      end else if (d0cnt != 0) d0cnt <= d0cnt - 1;
      if (div1_wr) begin
        d1cnt  <= $urandom_range(6, 1);
        d1busy <= ($urandom() | 32'h1) & 32'h0000_0011;
      end else if (d1cnt != 0) d1cnt <= d1cnt - 1;
      if (mux_sel != mux_tgt) begin
        mux_tgt <= mux_sel;
        mcnt    <= $urandom_range(5, 2);
        mst     <= 3'b000;
      end else if (mcnt != 0) begin
        mcnt <= mcnt - 1;
        if (mcnt == 1) mst <= mux_tgt ? 3'b010 : 3'b001;
      end
      if (pll_wr) begin
        lk   <= 1'b0;
        pcnt <= int'(lock_time);
      end else if (!lk) begin
        if (pcnt <= 1) lk <= 1'b1;
        else pcnt <= pcnt - 1;
      end
    end
  end

  // ---------------- expected tables ----------------
  function automatic int e_p(int l);
    case (l) 2: return 4; 8: return 6; default: return 3; endcase
  endfunction
  function automatic int e_m(int l);
    case (l)
      0, 1, 3: return 100; 2, 7: return 200; 4: return 125;
      5: return 150; 6: return 175; default: return 425;
    endcase
  endfunction
  function automatic int e_s(int l);
    case (l) 0: return 2; 1, 2: return 1; default: return 0; endcase
  endfunction
  function automatic logic [31:0] e_div0(int l);
    case (l)
      0: return 32'h0111_7710; 1: return 32'h0112_7710; 2: return 32'h0113_7710;
      3: return 32'h0214_7710; 4: return 32'h0214_7710; 5: return 32'h0315_7720;
      6: return 32'h0416_7720; 7: return 32'h0417_7730; default: return 32'h0537_7730;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push(input int k, input int l, input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    e.kind = k; e.lvl = l; e.a = a; e.b = b;
    q.push_back(e);
  endtask

  task automatic push_level(input int l);
    logic [31:0] con;
    con = {1'b1, 5'b0, 10'(e_m(l)), 2'b0, 6'(e_p(l)), 5'b0, 3'(e_s(l))};
    push(K_DIV0, l, e_div0(l), 0);
    push(K_DIV1, l, 32'd32, 0);
    push(K_MUX,  l, 32'd1, 0);
    push(K_PLL,  l, con, 32'(e_p(l) * 250));
    push(K_MUX,  l, 32'd0, 0);
    push(K_DONE, l, 32'(l), 0);
  endtask

  // driver: pushes expectations, then completes the handshake
  task automatic send_req(input int l, output int waited);
    if (l < 9) push_level(l); else push(K_REJ, l, 0, 0);
    waited = 0;
    @(negedge clk);
    req_valid = 1'b1;
    req_level = 4'(l);
    while (!req_ready) begin
      @(negedge clk);
      waited++;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(req_ready && q.size() == 0));
  endtask

  // ---------------- monitor ----------------
  task automatic handle(input int k, input logic [31:0] a, input logic [31:0] b);
    exp_t e;
    int   f, fexp;
    if (q.size() == 0) begin
      chk(0, "R7 unexpected event", 32'(k), 32'hFFFF_FFFF);
      return;
    end
    e = q.pop_front();
    chk(e.kind == k, "R7 step order", 32'(k), 32'(e.kind));
    if (e.kind != k) return;
    case (k)
      K_DIV0: chk(a == e.a, "R2 div0 word", a, e.a);
      K_DIV1: begin
        chk(a == e.a, "R3 div1 word", a, e.a);
        chk((div0_stat & 32'h1111_1111) == 0, "R2 div0 busy clear", div0_stat, 0);
      end
      K_MUX: begin
        chk(a == e.a, "R6 mux select", a, e.a);
        if (a == 1) chk((div1_stat & 32'h11) == 0, "R3 div1 busy clear", div1_stat, 0);
        else        chk(pll_locked == 1'b1, "R6 locked before return", 32'(pll_locked), 1);
      end
      K_PLL: begin
        chk(a == e.a, "R5 pll word", a, e.a);
        chk(b == e.b, "R4 lock time", b, e.b);
        chk(mux_stat == 3'b010, "R6 parked at pll write", 32'(mux_stat), 32'h2);
        chk(int'(cur_level) == last_level, "R7 level held mid-run", 32'(cur_level), 32'(last_level));
        f    = int'(a[25:16]) * 24 / (int'(a[13:8]) << a[2:0]);
        fexp = (e.lvl == 8) ? 1700 : 200 * (e.lvl + 1);
        chk(f == fexp, "R5 nominal MHz", 32'(f), 32'(fexp));
      end
      K_DONE: begin
        chk(a == e.a, "R7 level at done", a, e.a);
        chk(mux_stat == 3'b001, "R6 back on primary", 32'(mux_stat), 32'h1);
        last_level = int'(a);
      end
      default:
        chk(int'(cur_level) == last_level, "R1 reject keeps level", 32'(cur_level), 32'(last_level));
    endcase
  endtask

  always @(negedge clk) begin
    if (rst) prev_mux = 1'b0;
    else begin
      if (div0_wr) handle(K_DIV0, div0_word, 0);
      if (div1_wr) handle(K_DIV1, div1_word, 0);
      if (mux_sel != prev_mux) handle(K_MUX, {31'b0, mux_sel}, 0);
      if (pll_wr) handle(K_PLL, pll_con, {12'b0, lock_time});
      if (done) handle(K_DONE, {28'b0, cur_level}, 0);
      if (rejected) handle(K_REJ, 0, 0);
      prev_mux = mux_sel;
    end
  end

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // ---------------- main sequence ----------------
  initial begin
    int w;
    push_level(7);                       // R8 boot change
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(div0_word == 0 && div1_word == 0 && pll_con == 0 && lock_time == 0,
        "R10 reset registers", pll_con | div0_word, 0);
    chk(!mux_sel && cur_level == 0, "R10 reset mux/level", {31'b0, mux_sel} | 32'(cur_level), 0);
    chk(!req_ready && !done && !rejected, "R10 reset handshake", 32'(req_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!req_ready, "R8 no ack during boot", 32'(req_ready), 0);
    wait_idle();
    chk(cur_level == 4'd7, "R8 boot level", 32'(cur_level), 7);

    send_req(9, w);                      // R1 out of range
    repeat (3) @(negedge clk);
    chk(cur_level == 4'd7 && !mux_sel, "R1 rejected leaves state", 32'(cur_level), 7);
    send_req(15, w);
    wait_idle();

    for (int l = 0; l < 9; l++) begin    // R1/R2/R5 all levels
      send_req(l, w);
    end
    send_req(12, w);                     // R9 held while busy
    chk(w > 0, "R9 request waited for idle", 32'(w), 1);
    send_req(3, w);
    send_req(8, w);
    wait_idle();
    chk(cur_level == 4'd8, "R7 final level", 32'(cur_level), 8);
    chk(q.size() == 0, "R9 all requests served", 32'(q.size()), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule